// File: doc/BRIEF.md
# SMBus Master Transaction Sequencer

This block turns one SMBus request into the full series of byte-level controls for an I2C master engine. The engine moves one byte at a time and reports each byte boundary. The sequencer decides what happens at each boundary: START, repeated START, STOP, which byte to load next, whether the byte being received gets an acknowledge, and where a received byte goes. Bit timing on SCL and SDA belongs to the engine and is not part of this block.

A client offers a request on a valid/ready handshake. The request carries a 7-bit target, a direction flag, a command byte, a transaction kind and a block length. Bytes to transmit are fetched through an index/data lookup port. Received bytes are stored in an internal buffer, which the client reads back through a second index/data port. When the transaction ends, a one-cycle `done` pulse carries a result code, and a sticky flag tells the client whether the engine should be reinitialised before further use.

Top module: `smb_txn_sequencer`

## Requirements
- R1: `req_ready` is high only while no transaction is in progress. An accepted valid request produces, on the next cycle, either an `eng_start` pulse or a `done` pulse, never both.
- R2: A quick or single-byte transaction starts directly with the target byte {addr, dir}, where bit 0 = 1 means read.
- R3: Byte-data, word and block transactions first send {addr, 0} and then the command byte. A read then issues a repeated START and sends {addr, 1}. A write goes straight on to the data bytes.
- R4: `eng_nack_ctl` is high while the final byte of a read is being received, and low while every earlier byte is received. A one-byte read raises it as soon as the read target byte is loaded.
- R5: Data bytes go out in index order, starting at `wr_index` 0, so a word sends its low byte first. The k-th received byte is stored at buffer index k. A read ends on the final byte, and a write ends once no bytes remain. Either ending pulses `eng_stop` and reports result code 0 (success).
- R6: A negative acknowledge in any busy state pulses `eng_stop` and `eng_clr_status` and ends the transaction with code 1 (no device). `needs_reset` stays low.
- R7: A bus error, or an event arriving while `eng_master` is low, ends the transaction with code 2 (I/O error) and sets `needs_reset`. No STOP is issued.
- R8: A read of zero length, a block length of 0 or greater than 32, and a kind code of 5 to 7 are all rejected with code 3 (invalid). Rejection causes no START and no STOP. Kind codes: 0 quick, 1 byte, 2 byte-data, 3 word, 4 block.
- R9: If no event arrives within TIMEOUT_CYCLES clock cycles of the previous event or of acceptance, the transaction ends with code 2 and `needs_reset` is set.
- R10: Engine events that arrive while idle produce no START, STOP or byte load.
- R11: `done` is high for one cycle only. `needs_reset` is cleared when a new request is accepted.
- R12: A single-byte write sends `req_cmd` as its only data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | 7 | Target address |
| req_read | input | 1 | 1 = read transaction |
| req_cmd | input | 8 | Command byte (data byte for single-byte write) |
| req_kind | input | 3 | Transaction kind code |
| req_len | input | 6 | Block length |
| wr_index | output | 5 | Index of next byte to transmit |
| wr_data | input | 8 | Byte at `wr_index` |
| rd_index | input | 5 | Receive buffer read index |
| rd_data | output | 8 | Receive buffer byte at `rd_index` |
| eng_start | output | 1 | START / repeated START request pulse |
| eng_stop | output | 1 | STOP request pulse |
| eng_nack_ctl | output | 1 | Do not acknowledge the byte being received |
| eng_tx_valid | output | 1 | Load `eng_tx_byte` into engine |
| eng_tx_byte | output | 8 | Byte to transmit |
| eng_clr_status | output | 1 | Clear stall and negative-ack status |
| eng_data_rdy | input | 1 | Byte boundary reached |
| eng_bus_err | input | 1 | Bus error event |
| eng_nack | input | 1 | Negative acknowledge event |
| eng_master | input | 1 | Engine still holds the bus |
| eng_rx_byte | input | 8 | Received byte, valid with `eng_data_rdy` |
| done | output | 1 | Transaction complete pulse |
| done_code | output | 2 | Result code |
| needs_reset | output | 1 | Engine must be reinitialised |

## Verification
The hardest behaviour to reach is the acknowledge decision one byte ahead during reads. It depends on when the engine model reports each received byte relative to when the sequencer updates `eng_nack_ctl`. The bench engine model records the control level at each reported byte, for reads of one, two and three bytes. Fault paths are reached by counting engine events and replacing a chosen one with a negative acknowledge, a bus error or a lost-master indication. A silent model that never answers exercises the timeout.

// File: rtl/smb_seq_pkg.sv
// Shared types for the SMBus transaction sequencer.
// Assumes: kind and result encodings are fixed by the requirements.
package smb_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_RSTART,
        ST_QUICK,
        ST_READ,
        ST_WRITE
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_NODEV = 2'd1,
        RES_IOERR = 2'd2,
        RES_INVAL = 2'd3
    } result_t;

    localparam logic [2:0] KIND_QUICK = 3'd0;
    localparam logic [2:0] KIND_BYTE  = 3'd1;
    localparam logic [2:0] KIND_BDATA = 3'd2;
    localparam logic [2:0] KIND_WORD  = 3'd3;
    localparam logic [2:0] KIND_BLOCK = 3'd4;

endpackage

// File: rtl/smb_req_decode.sv
// Request decoder: maps kind/direction/length to a transfer length,
// the entry state choice and a reject flag.
// Assumes: purely combinational, inputs stable while req_valid is high.
module smb_req_decode #(
    parameter int MAX_BLOCK = 32,
    parameter int LEN_W     = $clog2(MAX_BLOCK + 1)
) (
    input  logic [2:0]       kind,
    input  logic             is_read,
    input  logic [LEN_W-1:0] blk_len,
    output logic [LEN_W-1:0] xfer_len,
    output logic             short_form,
    output logic             reject
);
    import smb_seq_pkg::*;

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BLOCK);

    // Decode transfer shape from kind code.
    always_comb begin
        xfer_len   = '0;
        short_form = 1'b0;
        reject     = 1'b0;
        case (kind)
            KIND_QUICK: begin
                short_form = 1'b1;
            end
            KIND_BYTE: begin
                xfer_len   = LEN_W'(1);
                short_form = 1'b1;
            end
            KIND_BDATA: xfer_len = LEN_W'(1);
            KIND_WORD:  xfer_len = LEN_W'(2);
            KIND_BLOCK: begin
                xfer_len = blk_len;
                reject   = (blk_len == '0) || (blk_len > MAX_LEN);
            end
            default: reject = 1'b1;
        endcase
        if (is_read && (xfer_len == '0)) begin
            reject = 1'b1;
        end
    end

endmodule

// File: rtl/smb_evt_timer.sv
// Inactivity timer: counts cycles since the last reload while active and
// flags expiry after LIMIT cycles.
// Assumes: LIMIT >= 2; the count holds at LIMIT until reloaded.
module smb_evt_timer #(
    parameter int LIMIT = 1000,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic active,
    output logic expired
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count idle cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || reload || !active) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = active && (cnt == LIM);

endmodule

// File: rtl/smb_rx_buf.sv
// Receive buffer: one write port fed by the sequencer, one combinational
// read port for the client.
// Assumes: contents are undefined after reset until written.
module smb_rx_buf #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    logic [7:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Capture the incoming byte into entry g.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent[g] <= wr_byte;
            end
        end
    end

    assign rd_byte = ent[rd_idx];

endmodule

// File: rtl/smb_txn_sequencer.sv
// SMBus transaction sequencer: drives a byte-level I2C master engine
// through quick, byte, byte-data, word and block transactions.
// Assumes: engine events are single-cycle pulses; outputs to the engine
// are registered and appear the cycle after the event that causes them.
module smb_txn_sequencer #(
    parameter int MAX_BLOCK      = 32,
    parameter int TIMEOUT_CYCLES = 25_000_000,
    parameter int LEN_W          = $clog2(MAX_BLOCK + 1),
    parameter int IDX_W          = $clog2(MAX_BLOCK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [6:0]       req_addr,
    input  logic             req_read,
    input  logic [7:0]       req_cmd,
    input  logic [2:0]       req_kind,
    input  logic [LEN_W-1:0] req_len,
    output logic [IDX_W-1:0] wr_index,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_index,
    output logic [7:0]       rd_data,
    output logic             eng_start,
    output logic             eng_stop,
    output logic             eng_nack_ctl,
    output logic             eng_tx_valid,
    output logic [7:0]       eng_tx_byte,
    output logic             eng_clr_status,
    input  logic             eng_data_rdy,
    input  logic             eng_bus_err,
    input  logic             eng_nack,
    input  logic             eng_master,
    input  logic [7:0]       eng_rx_byte,
    output logic             done,
    output logic [1:0]       done_code,
    output logic             needs_reset
);
    import smb_seq_pkg::*;

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    seq_state_t       state;
    logic [6:0]       t_addr;
    logic             t_read;
    logic [7:0]       t_cmd;
    logic [2:0]       t_kind;
    logic [LEN_W-1:0] remain;
    logic [IDX_W-1:0] idx;
    result_t          code_q;

    logic [LEN_W-1:0] dec_len;
    logic             dec_short;
    logic             dec_reject;
    logic             accept;
    logic             evt;
    logic             fault;
    logic             tmo;
    logic             rx_we;
    logic [7:0]       next_tx;

    smb_req_decode #(.MAX_BLOCK(MAX_BLOCK), .LEN_W(LEN_W)) u_dec (
        .kind      (req_kind),
        .is_read   (req_read),
        .blk_len   (req_len),
        .xfer_len  (dec_len),
        .short_form(dec_short),
        .reject    (dec_reject)
    );

    smb_evt_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (accept || evt),
        .active (state != ST_IDLE),
        .expired(tmo)
    );

    smb_rx_buf #(.DEPTH(MAX_BLOCK), .IDX_W(IDX_W)) u_rxb (
        .clk    (clk),
        .wr_en  (rx_we),
        .wr_idx (idx),
        .wr_byte(eng_rx_byte),
        .rd_idx (rd_index),
        .rd_byte(rd_data)
    );

    // Qualify engine events and select the next outgoing data byte.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
        evt       = eng_data_rdy || eng_bus_err || eng_nack;
        fault     = eng_bus_err || !eng_master;
        rx_we     = (state == ST_READ) && evt && !fault && !eng_nack;
        next_tx   = (t_kind == KIND_BYTE) ? t_cmd : wr_data;
    end

    assign wr_index  = idx;
    assign done_code = code_q;

    // Main transaction state machine with registered engine controls.
    always_ff @(posedge clk) begin
        eng_start      <= 1'b0;
        eng_stop       <= 1'b0;
        eng_tx_valid   <= 1'b0;
        eng_clr_status <= 1'b0;
        done           <= 1'b0;
        if (!rst_n) begin
            state        <= ST_IDLE;
            t_addr       <= '0;
            t_read       <= 1'b0;
            t_cmd        <= '0;
            t_kind       <= '0;
            remain       <= '0;
            idx          <= '0;
            code_q       <= RES_OK;
            needs_reset  <= 1'b0;
            eng_nack_ctl <= 1'b0;
            eng_tx_byte  <= '0;
        end else if (state == ST_IDLE) begin
            if (accept) begin
                needs_reset  <= 1'b0;
                eng_nack_ctl <= 1'b0;
                t_addr       <= req_addr;
                t_read       <= req_read;
                t_cmd        <= req_cmd;
                t_kind       <= req_kind;
                remain       <= dec_len;
                idx          <= '0;
                if (dec_reject) begin
                    done   <= 1'b1;
                    code_q <= RES_INVAL;
                end else begin
                    eng_start <= 1'b1;
                    state     <= dec_short ? ST_QUICK : ST_ADDR;
                end
            end
        end else if (evt) begin
            if (fault) begin
                state       <= ST_IDLE;
                code_q      <= RES_IOERR;
                needs_reset <= 1'b1;
                done        <= 1'b1;
            end else if (eng_nack) begin
                eng_stop       <= 1'b1;
                eng_clr_status <= 1'b1;
                state          <= ST_IDLE;
                code_q         <= RES_NODEV;
                done           <= 1'b1;
            end else begin
                case (state)
                    ST_ADDR: begin
                        eng_tx_valid <= 1'b1;
                        eng_tx_byte  <= {t_addr, 1'b0};
                        state        <= ST_CMD;
                    end
                    ST_CMD: begin
                        eng_tx_valid <= 1'b1;
                        eng_tx_byte  <= t_cmd;
                        state        <= t_read ? ST_RSTART : ST_WRITE;
                    end
                    ST_RSTART, ST_QUICK: begin
                        if (state == ST_RSTART) begin
                            eng_start <= 1'b1;
                        end
                        eng_tx_valid <= 1'b1;
                        eng_tx_byte  <= {t_addr, t_read};
                        if (t_read) begin
                            eng_nack_ctl <= (remain == ONE);
                            state        <= ST_READ;
                        end else begin
                            state <= ST_WRITE;
                        end
                    end
                    ST_READ: begin
                        eng_nack_ctl <= (remain == TWO);
                        idx          <= idx + 1'b1;
                        remain       <= remain - 1'b1;
                        if (remain == ONE) begin
                            eng_stop <= 1'b1;
                            state    <= ST_IDLE;
                            code_q   <= RES_OK;
                            done     <= 1'b1;
                        end
                    end
                    ST_WRITE: begin
                        if (remain == '0) begin
                            eng_stop <= 1'b1;
                            state    <= ST_IDLE;
                            code_q   <= RES_OK;
                            done     <= 1'b1;
                        end else begin
                            eng_tx_valid <= 1'b1;
                            eng_tx_byte  <= next_tx;
                            idx          <= idx + 1'b1;
                            remain       <= remain - 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end else if (tmo) begin
            state       <= ST_IDLE;
            code_q      <= RES_IOERR;
            needs_reset <= 1'b1;
            done        <= 1'b1;
        end
    end

endmodule

// File: rtl/smb_txn_sequencer_chk.sv
// Property checker for the SMBus transaction sequencer, bound to the top.
// Assumes: observes top-level ports only.
module smb_txn_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       eng_start,
    input logic       eng_stop,
    input logic       eng_tx_valid,
    input logic       eng_clr_status,
    input logic       done,
    input logic [1:0] done_code,
    input logic       needs_reset
);
    AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (eng_start != done)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !req_ready); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !needs_reset); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> !(eng_start || eng_stop || eng_tx_valid)); // R10
    AST_OK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_code == 2'd0) |-> eng_stop); // R5
    AST_NODEV_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_code == 2'd1) |-> (eng_stop && eng_clr_status && !needs_reset)); // R6
    AST_IOERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_code == 2'd2) |-> (needs_reset && !eng_stop)); // R7
    AST_INVAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_code == 2'd3) |-> (!eng_start && !eng_stop)); // R8
endmodule

bind smb_txn_sequencer smb_txn_sequencer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .eng_start     (eng_start),
    .eng_stop      (eng_stop),
    .eng_tx_valid  (eng_tx_valid),
    .eng_clr_status(eng_clr_status),
    .done          (done),
    .done_code     (done_code),
    .needs_reset   (needs_reset)
);

// File: tb/test_smb_txn_sequencer.sv
`timescale 1ns/1ps
module test_smb_txn_sequencer;
    localparam int TMO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [6:0] req_addr = '0;
    logic       req_read = 1'b0;
    logic [7:0] req_cmd = '0;
    logic [2:0] req_kind = '0;
    logic [5:0] req_len = '0;
    logic [4:0] wr_index;
    logic [7:0] wr_data;
    logic [4:0] rd_index = '0;
    logic [7:0] rd_data;
    logic       eng_start, eng_stop, eng_nack_ctl, eng_tx_valid, eng_clr_status;
    logic [7:0] eng_tx_byte;
    logic       eng_data_rdy = 1'b0, eng_bus_err = 1'b0, eng_nack = 1'b0, eng_master = 1'b1;
    logic [7:0] eng_rx_byte = '0;
    logic       done;
    logic [1:0] done_code;
    logic       needs_reset;

    always #4 clk = ~clk;

    smb_txn_sequencer #(.TIMEOUT_CYCLES(TMO)) i_smb_txn_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_read(req_read), .req_cmd(req_cmd),
        .req_kind(req_kind), .req_len(req_len), .wr_index(wr_index),
        .wr_data(wr_data), .rd_index(rd_index), .rd_data(rd_data),
        .eng_start(eng_start), .eng_stop(eng_stop), .eng_nack_ctl(eng_nack_ctl),
        .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
        .eng_clr_status(eng_clr_status), .eng_data_rdy(eng_data_rdy),
        .eng_bus_err(eng_bus_err), .eng_nack(eng_nack), .eng_master(eng_master),
        .eng_rx_byte(eng_rx_byte), .done(done), .done_code(done_code),
        .needs_reset(needs_reset)
    );

    logic [7:0] wmem [32];
    assign wr_data = wmem[wr_index];

    // Engine model state and logs.
    logic [7:0] tx_log [40];
    logic       nk_log [40];
    int tx_n, start_n, stop_n, clr_n, rx_n, done_n, ev_num, cd;
    logic after_start, rd_mode, clr_log = 1'b0, stray = 1'b0;
    int inj_at = 0, inj_kind = 0;
    logic [1:0] got_code;
    logic got_nr;
    int checks = 0, errors = 0;
    bit finished = 0;

    // Behavioural byte engine: answers each START/byte load after 4 cycles.
    always @(posedge clk) begin
        eng_data_rdy <= 1'b0;
        eng_bus_err  <= 1'b0;
        eng_nack     <= 1'b0;
        eng_master   <= 1'b1;
        if (clr_log) begin
            tx_n <= 0; start_n <= 0; stop_n <= 0; clr_n <= 0; rx_n <= 0;
            done_n <= 0; ev_num <= 0; cd <= 0; after_start <= 0; rd_mode <= 0;
        end else begin
            if (stray) eng_data_rdy <= 1'b1;
            if (eng_start) start_n <= start_n + 1;
            if (eng_stop) stop_n <= stop_n + 1;
            if (eng_clr_status) clr_n <= clr_n + 1;
            if (done) begin
                done_n <= done_n + 1; got_code <= done_code; got_nr <= needs_reset;
            end
            if (eng_tx_valid) begin
                if (tx_n < 40) tx_log[tx_n] <= eng_tx_byte;
                tx_n <= tx_n + 1;
                if (eng_start || after_start) rd_mode <= eng_tx_byte[0];
                after_start <= 1'b0;
                cd <= 4;
            end else if (eng_start) begin
                after_start <= 1'b1;
                cd <= 4;
            end else if (eng_stop) begin
                cd <= 0;
            end else if (cd > 0) begin
                cd <= cd - 1;
                if (cd == 1) begin
                    ev_num <= ev_num + 1;
                    if (inj_kind == 4) begin
                        // silent engine
                    end else if (inj_kind != 0 && ev_num + 1 == inj_at) begin
                        if (inj_kind == 1) eng_nack <= 1'b1;
                        else if (inj_kind == 2) eng_bus_err <= 1'b1;
                        else begin eng_data_rdy <= 1'b1; eng_master <= 1'b0; end
                    end else begin
                        eng_data_rdy <= 1'b1;
                        if (rd_mode) begin
                            eng_rx_byte <= 8'(8'hA0 + rx_n);
                            if (rx_n < 40) nk_log[rx_n] <= eng_nack_ctl;
                            rx_n <= rx_n + 1;
                            cd <= 4;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [6:0] a, input logic rd, input logic [7:0] c,
                       input logic [2:0] k, input logic [5:0] l, output int cyc,
                       output logic busy_ready);
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0;
        req_addr = a; req_read = rd; req_cmd = c; req_kind = k; req_len = l;
        req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        busy_ready = req_ready;
        cyc = 0;
        while (done_n == 0 && cyc < 5000) begin
            @(negedge clk); cyc++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_rx(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            rd_index = 5'(i); #1;
            chk(rd_data == 8'(8'hA0 + i), req, "rx buffer byte", rd_data, 8'hA0 + i);
        end
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(done == 1'b0, "R11", "done after reset", done, 0);
        chk(needs_reset == 1'b0, "R7", "needs_reset after reset", needs_reset, 0);
        chk(eng_start == 1'b0 && eng_stop == 1'b0, "R10", "engine ctl after reset",
            {eng_start, eng_stop}, 0);
    endtask

    task automatic t_quick_write();
        int cyc; logic br;
        run(7'h50, 1'b0, 8'h00, 3'd0, 6'd0, cyc, br);
        chk(br == 1'b0, "R1", "ready while busy", br, 0);
        chk(tx_n == 1 && tx_log[0] == 8'hA0, "R2", "quick target byte", tx_log[0], 8'hA0);
        chk(start_n == 1 && stop_n == 1, "R5", "quick start/stop", {start_n[3:0], stop_n[3:0]}, 8'h11);
        chk(done_n == 1 && got_code == 2'd0, "R11", "quick done once ok", {done_n[3:0], 2'b0, got_code}, 8'h10);
    endtask

    task automatic t_byte_write();
        int cyc; logic br;
        run(7'h21, 1'b0, 8'h3C, 3'd1, 6'd0, cyc, br);
        chk(tx_n == 2 && tx_log[0] == 8'h42, "R2", "byte write target", tx_log[0], 8'h42);
        chk(tx_log[1] == 8'h3C, "R12", "byte write data is command", tx_log[1], 8'h3C);
        chk(got_code == 2'd0, "R5", "byte write result", got_code, 0);
    endtask

    task automatic t_bdata_write();
        int cyc; logic br;
        run(7'h2A, 1'b0, 8'h10, 3'd2, 6'd0, cyc, br);
        chk(tx_n == 3 && tx_log[0] == 8'h54 && tx_log[1] == 8'h10, "R3", "byte-data prefix",
            {tx_log[0], tx_log[1]}, 16'h5410);
        chk(tx_log[2] == wmem[0] && start_n == 1, "R3", "byte-data no restart", tx_log[2], wmem[0]);
    endtask

    task automatic t_word_read();
        int cyc; logic br;
        run(7'h48, 1'b1, 8'h07, 3'd3, 6'd0, cyc, br);
        chk(tx_n == 3 && tx_log[0] == 8'h90 && tx_log[1] == 8'h07 && tx_log[2] == 8'h91,
            "R3", "word read bytes", {tx_log[0], tx_log[1], tx_log[2]}, 24'h900791);
        chk(start_n == 2 && stop_n == 1, "R3", "word read restart", {start_n[3:0], stop_n[3:0]}, 8'h21);
        chk(nk_log[0] == 1'b0 && nk_log[1] == 1'b1, "R4", "word nack pattern",
            {nk_log[0], nk_log[1]}, 2'b01);
        chk(got_code == 2'd0 && rx_n == 2, "R5", "word read result", got_code, 0);
        chk_rx("R5", 2);
    endtask

    task automatic t_byte_read();
        int cyc; logic br;
        run(7'h33, 1'b1, 8'h00, 3'd1, 6'd0, cyc, br);
        chk(tx_n == 1 && tx_log[0] == 8'h67, "R2", "byte read target", tx_log[0], 8'h67);
        chk(rx_n == 1 && nk_log[0] == 1'b1, "R4", "single read nack", nk_log[0], 1);
        chk_rx("R5", 1);
    endtask

    task automatic t_block_read3();
        int cyc; logic br;
        run(7'h11, 1'b1, 8'h40, 3'd4, 6'd3, cyc, br);
        chk(nk_log[0] == 1'b0 && nk_log[1] == 1'b0 && nk_log[2] == 1'b1, "R4",
            "block3 nack pattern", {nk_log[0], nk_log[1], nk_log[2]}, 3'b001);
        chk_rx("R5", 3);
    endtask

    task automatic t_block_write32();
        int cyc; logic br;
        run(7'h0F, 1'b0, 8'hC1, 3'd4, 6'd32, cyc, br);
        chk(tx_n == 34, "R5", "block32 byte count", tx_n, 34);
        chk(tx_log[2] == wmem[0] && tx_log[33] == wmem[31], "R5", "block32 order",
            {tx_log[2], tx_log[33]}, {wmem[0], wmem[31]});
        chk(got_code == 2'd0 && stop_n == 1, "R5", "block32 result", got_code, 0);
    endtask

    task automatic t_invalid();
        int cyc; logic br;
        run(7'h10, 1'b0, 8'h00, 3'd4, 6'd0, cyc, br);
        chk(got_code == 2'd3 && start_n == 0, "R8", "block len 0", got_code, 3);
        run(7'h10, 1'b0, 8'h00, 3'd4, 6'd33, cyc, br);
        chk(got_code == 2'd3 && start_n == 0, "R8", "block len 33", got_code, 3);
        run(7'h10, 1'b1, 8'h00, 3'd0, 6'd0, cyc, br);
        chk(got_code == 2'd3 && start_n == 0 && stop_n == 0, "R8", "zero length read", got_code, 3);
        run(7'h10, 1'b0, 8'h00, 3'd6, 6'd1, cyc, br);
        chk(got_code == 2'd3 && tx_n == 0, "R8", "unknown kind", got_code, 3);
    endtask

    task automatic t_fault(input int kind, input string req, input logic [1:0] ec,
                           input logic enr, input int estop);
        int cyc; logic br;
        inj_kind = kind; inj_at = 2;
        run(7'h2A, 1'b0, 8'h10, 3'd2, 6'd0, cyc, br);
        inj_kind = 0;
        chk(got_code == ec, req, "fault result code", got_code, ec);
        chk(got_nr == enr, req, "fault needs_reset", got_nr, enr);
        chk(stop_n == estop, req, "fault stop count", stop_n, estop);
        if (kind == 1) chk(clr_n == 1, req, "nack status clear", clr_n, 1);
    endtask

    task automatic t_timeout();
        int cyc; logic br;
        inj_kind = 4;
        run(7'h2A, 1'b0, 8'h10, 3'd2, 6'd0, cyc, br);
        inj_kind = 0;
        chk(got_code == 2'd2 && got_nr == 1'b1, "R9", "timeout result", got_code, 2);
        chk(cyc >= TMO && cyc < TMO + 10, "R9", "timeout latency", cyc, TMO);
    endtask

    task automatic t_flag_clear();
        int cyc; logic br;
        run(7'h50, 1'b0, 8'h00, 3'd0, 6'd0, cyc, br);
        chk(needs_reset == 1'b0 && got_code == 2'd0, "R11", "needs_reset cleared", needs_reset, 0);
    endtask

    task automatic t_idle_event();
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0; stray = 1'b1;
        @(negedge clk); stray = 1'b0;
        repeat (6) @(negedge clk);
        chk(tx_n == 0 && start_n == 0 && stop_n == 0 && done_n == 0, "R10",
            "idle event ignored", tx_n + start_n + stop_n + done_n, 0);
        chk(req_ready == 1'b1, "R10", "still idle", req_ready, 1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) wmem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quick_write();
        t_byte_write();
        t_bdata_write();
        t_word_read();
        t_byte_read();
        t_block_read3();
        t_block_write32();
        t_invalid();
        t_fault(1, "R6", 2'd1, 1'b0, 1);
        t_fault(2, "R7", 2'd2, 1'b1, 0);
        t_fault(3, "R7", 2'd2, 1'b1, 0);
        t_timeout();
        t_flag_clear();
        t_idle_event();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule